// File: doc/BRIEF.md
# JTAG-to-SPI flash bridge

This bridge lets a serial flash attached to a chip be read, written and erased through plain data-register shifts of a JTAG chain. It works only while its user instruction sits in the instruction register and the TAP is in the shift-DR state. Within a single DR shift it skips the leading zeros that bypassed TAPs ahead of it push through. The first 1 it sees is a start marker. After the marker it collects a 32-bit cycle count, most significant bit first. It then runs exactly that many SPI clock cycles with chip select low. Any bits that follow are ignored, so read data can drain through the bypass registers behind it.

TDI is passed straight to MOSI, and TCK, gated, becomes the SPI clock. Read data returns on TDO through a one-bit data-register path. This keeps the loop latency from a written bit to its read-back equal to the number of enabled TAPs in the chain. The timing follows SPI mode 0: the flash samples MOSI on rising TCK, and MOSI and TDO change on falling TCK.

Top module: `jspi_bridge`

## Requirements
- R1: When either `sel_i` or `shift_i` is low, `cs_no` is high and `sclk_o` low at once, without waiting for a clock edge, and the bridge goes back to searching for a marker. A 1 on `tdi_i` while the bridge is inactive does not start a transaction.
- R2: While the bridge searches for a marker, zeros on `tdi_i` cause no chip-select assertion and no SPI clock pulse.
- R3: The first 1 seen on `tdi_i` while searching is the start marker. It produces no SPI clock pulse.
- R4: The 32 bits after the marker form the cycle count, most significant bit first. No SPI clock pulse occurs while they are shifted in.
- R5: For a count N greater than zero, exactly N TCK cycles are counted right after the header. During them `cs_no` is low and one `sclk_o` pulse occurs per cycle. `cs_no` goes low on the falling TCK edge before the first pulse and returns high on the falling edge after the last pulse.
- R6: `mosi_o` equals `tdi_i` at all times. During the counted cycles `sclk_o` is high while TCK is high. Outside those cycles `sclk_o` stays low.
- R7: Once the counted cycles are done, further shift bits, 1s included, cause no chip select and no clock pulse until the bridge becomes inactive.
- R8: A count of zero ends the transaction with no chip-select assertion and no clock pulse.
- R9: The one-bit data register captures on rising TCK while the bridge is active. It takes `miso_i` during a counted cycle and `tdi_i` otherwise, and it holds its value while the bridge is inactive. `tdo_o` takes the captured bit on the following falling TCK edge.
- R10: During reset `cs_no` is high, `sclk_o` is low and `tdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | JTAG test clock, also the SPI clock source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | User instruction loaded in the IR |
| shift_i | input | 1 | TAP in shift-DR state |
| tdi_i | input | 1 | Serial data in from the chain |
| miso_i | input | 1 | Flash serial data out |
| tdo_o | output | 1 | Serial data out to the chain |
| sclk_o | output | 1 | Gated SPI clock |
| mosi_o | output | 1 | Serial data to the flash |
| cs_no | output | 1 | Active-low flash chip select |

## Verification
The bench sends frames that vary the number of leading zeros (none, one, several) and the cycle count (1, 5, 12 and 0). This tells apart a count that is off by one at either end, a marker bit that leaks through as a clock pulse, and a zero count that still asserts chip select. Trailing bits alternate 1 and 0, so a bridge that re-arms on a later 1 is caught. One frame is cut off mid-transfer by dropping shift-DR, and 1s are driven while the bridge is deselected. Together these show that chip select is released at once and that only a fresh marker starts the next transaction. On every active cycle TDO is compared against either MISO or TDI, which separates the transfer-window data path from the bypass-like path.

// File: rtl/jspi_pkg.sv
package jspi_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH,
    ST_LEN,
    ST_XFER,
    ST_DONE
  } jspi_st_e;
endpackage

// File: rtl/jspi_frame.sv
module jspi_frame
  import jspi_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic     tck_i,
  input  logic     rst_ni,
  input  logic     active_i,
  input  logic     tdi_i,
  output jspi_st_e state_o
);
  localparam int CNT_W = $clog2(LEN_W);

  jspi_st_e         state_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_nxt;

  assign len_nxt = {len_q[LEN_W-2:0], tdi_i};

  // len_q holds the header while shifting, then the remaining cycle count
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEARCH;
      len_q   <= '0;
      cnt_q   <= '0;
    end else if (!active_i) begin
      state_q <= ST_SEARCH;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_SEARCH: begin
          if (tdi_i) begin
            state_q <= ST_LEN;
            len_q   <= '0;
            cnt_q   <= '0;
          end
        end
        ST_LEN: begin
          len_q <= len_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(LEN_W - 1)) begin
            state_q <= (len_nxt == '0) ? ST_DONE : ST_XFER;
          end
        end
        ST_XFER: begin
          len_q <= len_q - 1'b1;
          if (len_q == LEN_W'(1)) state_q <= ST_DONE;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/jspi_gate.sv
module jspi_gate (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic xfer_i,
  output logic en_o,
  output logic sclk_o,
  output logic cs_no
);
  logic en_q;

  // enable moves only while TCK is low, so the gated clock has no runt pulse
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= xfer_i;
  end

  assign en_o   = en_q;
  assign sclk_o = tck_i & en_q & active_i;
  assign cs_no  = ~(en_q & active_i);
endmodule

// File: rtl/jspi_dr.sv
module jspi_dr (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic en_i,
  input  logic tdi_i,
  input  logic miso_i,
  output logic tdo_o
);
  logic dr_q;
  logic tdo_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       dr_q <= 1'b0;
    else if (active_i) dr_q <= en_i ? miso_i : tdi_i;
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) tdo_q <= 1'b0;
    else         tdo_q <= dr_q;
  end

  assign tdo_o = tdo_q;
endmodule

// File: rtl/jspi_bridge.sv
module jspi_bridge
  import jspi_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic shift_i,
  input  logic tdi_i,
  input  logic miso_i,
  output logic tdo_o,
  output logic sclk_o,
  output logic mosi_o,
  output logic cs_no
);
  logic     active;
  logic     xfer;
  logic     en;
  jspi_st_e state;

  assign active = sel_i & shift_i;
  assign xfer   = (state == ST_XFER);
  assign mosi_o = tdi_i;

  jspi_frame #(.LEN_W(LEN_W)) i_frame (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .tdi_i   (tdi_i),
    .state_o (state)
  );

  jspi_gate i_gate (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .xfer_i  (xfer),
    .en_o    (en),
    .sclk_o  (sclk_o),
    .cs_no   (cs_no)
  );

  jspi_dr i_dr (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .en_i    (en),
    .tdi_i   (tdi_i),
    .miso_i  (miso_i),
    .tdo_o   (tdo_o)
  );
endmodule

// File: rtl/jspi_bridge_chk.sv
module jspi_bridge_chk
  import jspi_pkg::*;
(
  input logic     tck_i,
  input logic     rst_ni,
  input logic     sel_i,
  input logic     shift_i,
  input logic     tdi_i,
  input logic     miso_i,
  input logic     tdo_o,
  input logic     cs_no,
  input jspi_st_e state_i,
  input logic     en_i
);
  logic act;
  assign act = sel_i && shift_i;

  p_inactive_cs_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !act |-> cs_no);

  p_zero_ignored_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_SEARCH && act && !tdi_i) |=> state_i == ST_SEARCH);

  p_marker_start_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_SEARCH && act && tdi_i) |=> state_i == ST_LEN);

  p_done_holds_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_DONE && act) |=> state_i == ST_DONE);

  p_tdo_bypass_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (act && !en_i) |=> tdo_o == $past(tdi_i));

  p_tdo_miso_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (act && en_i) |=> tdo_o == $past(miso_i));
endmodule

bind jspi_bridge jspi_bridge_chk i_chk (
  .tck_i  (tck_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .shift_i(shift_i),
  .tdi_i  (tdi_i),
  .miso_i (miso_i),
  .tdo_o  (tdo_o),
  .cs_no  (cs_no),
  .state_i(state),
  .en_i   (en)
);

// File: tb/test_jspi_bridge.sv
module test_jspi_bridge;
  logic tck = 1'b0;
  logic rst_n;
  logic sel = 1'b0, shift = 1'b0, tdi = 1'b0, miso = 1'b0;
  logic tdo, sclk, mosi, cs_n;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    bit    act;
    bit    flag;
    bit    d;
    bit    m;
    string req;
  } item_t;
  item_t q[$];

  always #2 tck = ~tck;

  jspi_bridge i_jspi_bridge (
    .tck_i  (tck),
    .rst_ni (rst_n),
    .sel_i  (sel),
    .shift_i(shift),
    .tdi_i  (tdi),
    .miso_i (miso),
    .tdo_o  (tdo),
    .sclk_o (sclk),
    .mosi_o (mosi),
    .cs_no  (cs_n)
  );

  task automatic chk(bit ok, string req, string what, int act_v, int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act_v, exp_v, $time);
    end
  endtask

  task automatic drive(bit s, bit sh, bit d, bit f, string req);
    item_t it;
    @(negedge tck);
    sel   = s;
    shift = sh;
    tdi   = d;
    miso  = 1'($urandom % 2);
    it.act = s && sh; it.flag = f; it.d = d; it.m = miso; it.req = req;
    q.push_back(it);
  endtask

  task automatic frame(int nz, int len, int tail, int abort_at, string hdr_req);
    logic [31:0] lv = 32'(len);
    for (int i = 0; i < nz; i++) drive(1, 1, 0, 0, "R2");
    drive(1, 1, 1, 0, "R3");
    for (int i = 31; i >= 0; i--) drive(1, 1, lv[i], 0, hdr_req);
    for (int i = 0; i < len; i++) begin
      if (i == abort_at) begin
        drive(1, 0, 0, 0, "R1");
        #1 chk(cs_n == 1'b1, "R1", "cs_no right after shift drop", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1", "sclk_o after shift drop", int'(sclk), 0);
        drive(1, 0, 1, 0, "R1");
        drive(0, 1, 1, 0, "R1");
        return;
      end
      drive(1, 1, 1'($urandom % 2), 1, "R5");
    end
    for (int i = 0; i < tail; i++) drive(1, 1, 1'(~i[0]), 0, "R7");
    drive(0, 1, 0, 0, "R1");
    drive(1, 0, 1, 0, "R1");
  endtask

  // monitor: compares outputs with queued expectations
  initial begin
    item_t it;
    bit exp_tdo = 1'b0;
    bit exp_x;
    forever begin
      @(posedge tck);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        exp_x = it.act && it.flag;
        chk(cs_n == !exp_x, it.req, "cs_no", int'(cs_n), int'(!exp_x));
        chk(sclk == exp_x, (it.flag ? "R6" : it.req), "sclk_o high phase", int'(sclk), int'(exp_x));
        chk(mosi == it.d, "R6", "mosi_o", int'(mosi), int'(it.d));
        @(negedge tck);
        #1;
        if (it.act) exp_tdo = exp_x ? it.m : it.d;
        chk(tdo == exp_tdo, "R9", "tdo_o", int'(tdo), int'(exp_tdo));
        if (!exp_x) chk(sclk == 1'b0, it.req, "sclk_o low phase", int'(sclk), 0);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    fork
      begin
        #9;
        chk(cs_n == 1'b1, "R10", "cs_no in reset", int'(cs_n), 1);
        chk(sclk == 1'b0, "R10", "sclk_o in reset", int'(sclk), 0);
        chk(tdo == 1'b0, "R10", "tdo_o in reset", int'(tdo), 0);
        @(negedge tck);
        rst_n = 1'b1;
        drive(0, 0, 0, 0, "R1");
        frame(3, 5, 4, -1, "R4");
        frame(0, 1, 3, -1, "R4");
        frame(7, 0, 5, -1, "R8");
        frame(1, 12, 2, -1, "R4");
        frame(1, 40, 0, 10, "R4");
        frame(0, 3, 2, -1, "R4");
        for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, "R1");
        for (int i = 0; i < 3; i++) drive(1, 0, 1, 0, "R1");
        frame(2, 2, 1, -1, "R4");
        for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, "R1");
        repeat (4) @(posedge tck);
      end
      begin
        repeat (50000) @(posedge tck);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule